// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a bus-mapped watchdog. A divide-by-32 prescaler feeds a tick counter whose limit is a power of two, 2^ps ticks, with ps taken from a 5-bit field of the control word. When the limit is reached, the block sends a one-clock reset request to the system and sets a sticky timeout flag in a separate status word. The reset request is not allowed to clear that flag; only the power-on reset clears it.

Software keeps the timer alive by writing the 16-bit restart key 0x5743 as a halfword into the upper half of the control word. Any other value, or any other access width, leaves the count untouched. The enable bit is normally turned on and off through the SET and CLR alias addresses. In the cycle right after the enable bit falls, the block ignores every access.

The window-enable bit and the clock-select field are stored and read back but do not change the timing.

Top module: `wdg_keyed_timer`

## Requirements
- R1: While rst_n is low, CTRL (byte address 0x00) reads 0 and wdt_rst_req is low. While por_n is low, STATUS (0x10) reads 0.
- R2: A plain write to CTRL updates bits 7:0 when bus_be[0] is set and bits 15:8 when bus_be[1] is set. Only bit 0 (window enable), bits 7:6 (clock select), bits 12:8 (ps) and bit 15 (enable) hold values; every other bit reads 0.
- R3: A write to 0x08 sets, and a write to 0x04 clears, exactly the CTRL bits that are 1 in bus_wdata[15:0]. All other CTRL bits are left unchanged.
- R4: With enable at 1, wdt_rst_req goes high for exactly one cycle, 32*2^ps cycles after the edge that set enable. It then repeats every 32*2^ps cycles.
- R5: A write to 0x00 with bus_be = 4'b1100 and bus_wdata[31:16] = 0x5743, made while enabled, restarts the prescaler and the counter. The next pulse comes 32*2^ps cycles after that write's edge.
- R6: A halfword write with a value other than the key, or the key written with bus_be other than 4'b1100, does not move the next pulse.
- R7: A key written while enable is 0 has no effect. No pulse appears and CTRL is unchanged.
- R8: While enable is 0, the count holds at zero. Enabling again gives a full 32*2^ps period.
- R9: Each timeout sets STATUS bit 4. The bit survives rst_n. It is cleared only by por_n or by a write with bit 4 set to 0x14. Plain writes to 0x10 have no effect on it.
- R10: In the one cycle after enable falls from 1 to 0, writes are ignored and bus_rdata reads 0.
- R11: The window-enable bit and the clock-select field do not change the timeout period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| por_n | input | 1 | Asynchronous power-on reset for the status flag, active low |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
Register writes land on the edge that captures them and can be read back combinationally half a cycle later. The enable-fall ignore window covers exactly the next capture edge. The reset request is registered, so it rises N = 32*2^ps edges after the enabling or key edge, and the status flag rises on that same edge. The bench drives on falling edges and counts falling edges from the capture edge to the first high request, so a measured count of N is exact. It sweeps ps from 0 to 4 with varied window and clock-select bits, and measures keys, wrong keys, disables and guard-cycle writes against the same counted schedule.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = 32;
  localparam int PS_W   = 5;

  localparam logic [ADDR_W-1:0] A_CTRL     = 5'h00;
  localparam logic [ADDR_W-1:0] A_CTRL_CLR = 5'h04;
  localparam logic [ADDR_W-1:0] A_CTRL_SET = 5'h08;
  localparam logic [ADDR_W-1:0] A_STAT     = 5'h10;
  localparam logic [ADDR_W-1:0] A_STAT_CLR = 5'h14;

  localparam int ON_BIT   = 15;
  localparam int PS_LO    = 8;
  localparam int FLAG_BIT = 4;

  localparam logic [15:0] CTRL_MASK   = 16'h9FC1;
  localparam logic [15:0] RESTART_KEY = 16'h5743;

  // last counter value before wrap: 2^ps - 1
  function automatic logic [CNT_W-1:0] term_last(input logic [PS_W-1:0] ps);
    logic [CNT_W-1:0] ones;
    ones = '1;
    return ones >> (CNT_W - int'(ps));
  endfunction
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic              flag,
  output logic [31:0]       bus_rdata,
  output logic              on,
  output logic [PS_W-1:0]   ps,
  output logic              key_seen,
  output logic              stat_clr
);
  logic [15:0] ctrl_q, ctrl_d;
  logic        guard_q;
  logic        wr_ok;

  assign wr_ok = bus_wr && !guard_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ok) begin
      case (bus_addr)
        A_CTRL: begin
          if (bus_be[0]) ctrl_d[7:0]  = bus_wdata[7:0];
          if (bus_be[1]) ctrl_d[15:8] = bus_wdata[15:8];
        end
        A_CTRL_CLR: ctrl_d = ctrl_q & ~bus_wdata[15:0];
        A_CTRL_SET: ctrl_d = ctrl_q | bus_wdata[15:0];
        default: ;
      endcase
    end
    ctrl_d = ctrl_d & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      guard_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      guard_q <= ctrl_q[ON_BIT] && !ctrl_d[ON_BIT];
    end
  end

  assign key_seen = wr_ok && (bus_addr == A_CTRL) && (bus_be == 4'b1100)
                    && (bus_wdata[31:16] == RESTART_KEY);
  assign stat_clr = wr_ok && (bus_addr == A_STAT_CLR) && bus_wdata[FLAG_BIT];
  assign on       = ctrl_q[ON_BIT];
  assign ps       = ctrl_q[PS_LO +: PS_W];

  always_comb begin
    bus_rdata = '0;
    if (!guard_q) begin
      if (bus_addr == A_CTRL) bus_rdata = {16'h0, ctrl_q};
      else if (bus_addr == A_STAT) bus_rdata[FLAG_BIT] = flag;
    end
  end

  // R10
  guard_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    guard_q |=> (ctrl_q == $past(ctrl_q)));
  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr == A_CTRL_SET) |=>
      ((ctrl_q & $past(bus_wdata[15:0] & CTRL_MASK)) == $past(bus_wdata[15:0] & CTRL_MASK)));
  // R3
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr == A_CTRL_CLR) |=> ((ctrl_q & $past(bus_wdata[15:0])) == 16'h0));
endmodule

// File: rtl/wdg_tick_count.sv
module wdg_tick_count
  import wdg_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            on,
  input  logic            key_seen,
  input  logic [PS_W-1:0] ps,
  output logic            fire,
  output logic            rst_req
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, at_term, restart;

  assign restart = on && key_seen;
  assign tick    = (pre_q == {PRE_W{1'b1}});
  assign at_term = (cnt_q >= term_last(ps));
  assign fire    = on && !restart && tick && at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= fire;
      if (!on || restart) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else begin
        pre_q <= pre_q + 1'b1;
        if (tick) cnt_q <= at_term ? '0 : cnt_q + 1'b1;
      end
    end
  end

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (pre_q == '0 && cnt_q == '0));
  // R5
  key_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0 && cnt_q == '0 && !rst_req));
  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R4
  pulse_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (pre_q == '0 && cnt_q == '0));
endmodule

// File: rtl/wdg_status.sv
module wdg_status (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  input  logic stat_clr,
  output logic flag
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        flag <= 1'b0;
    else if (fire)     flag <= 1'b1;
    else if (stat_clr) flag <= 1'b0;
  end

  // R9
  timeout_sets_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    fire |=> flag);
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!fire && !stat_clr) |=> $stable(flag));
endmodule

// File: rtl/wdg_keyed_timer.sv
module wdg_keyed_timer
  import wdg_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_req
);
  logic            on, key_seen, stat_clr, fire, flag;
  logic [PS_W-1:0] ps;

  wdg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .flag(flag), .bus_rdata(bus_rdata),
    .on(on), .ps(ps), .key_seen(key_seen), .stat_clr(stat_clr)
  );

  wdg_tick_count #(.PRE_W(PRE_W)) u_count (
    .clk(clk), .rst_n(rst_n), .on(on), .key_seen(key_seen), .ps(ps),
    .fire(fire), .rst_req(wdt_rst_req)
  );

  wdg_status u_status (
    .clk(clk), .por_n(por_n), .fire(fire), .stat_clr(stat_clr), .flag(flag)
  );
endmodule

// File: tb/sim_wdg_keyed_timer.sv
module sim_wdg_keyed_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdg_keyed_timer u0 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write is captured by the next rising edge
  task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_pulse(input int max, output int k);
    k = 0;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (wdt_rst_req) begin k = i; break; end
    end
  endtask

  task automatic count_pulses(input int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst_req) p++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int k, p, nper;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(5'h00, r); check("R1 ctrl", r, 32'h0);
    rd(5'h10, r); check("R1 status", r, 32'h0);
    check("R1 req", {31'b0, wdt_rst_req}, 32'h0);

    // R2 byte-enabled plain writes
    wr(5'h00, 4'b0001, 32'hFFFF_FFFF); rd(5'h00, r); check("R2 byte0", r, 32'h00C1);
    wr(5'h00, 4'b0010, 32'h0000_1F00); rd(5'h00, r); check("R2 byte1", r, 32'h1FC1);
    wr(5'h00, 4'b1111, 32'h0000_0000); rd(5'h00, r); check("R2 clear", r, 32'h0);

    // R3 alias writes
    wr(5'h08, 4'b1111, 32'h0000_0300); rd(5'h00, r); check("R3 set", r, 32'h0300);
    wr(5'h04, 4'b1111, 32'h0000_0100); rd(5'h00, r); check("R3 clr", r, 32'h0200);
    wr(5'h08, 4'b1111, 32'h0000_00C1); rd(5'h00, r); check("R3 set2", r, 32'h02C1);
    wr(5'h04, 4'b1111, 32'h0000_00C1); rd(5'h00, r); check("R3 clr2", r, 32'h0200);

    // R4 / R11 sweep over ps with varied window and clock-select bits
    for (int ps = 0; ps <= 4; ps++) begin
      logic [31:0] cv;
      nper = 32 << ps;
      cv = (32'(ps) << 8) | ((32'(ps) & 3) << 6) | (32'(ps) & 1);
      wr(5'h00, 4'b0011, cv);
      wr(5'h08, 4'b1111, 32'h0000_8000);
      wait_pulse(nper + 4, k); check("R4 R11 first period", k, nper);
      rd(5'h10, r); check("R9 flag set", r, 32'h10);
      @(negedge clk); check("R4 one cycle", {31'b0, wdt_rst_req}, 32'h0);
      wait_pulse(nper + 4, k); check("R4 repeat period", k, nper - 1);
      wr(5'h14, 4'b1111, 32'h10); rd(5'h10, r); check("R9 clr alias", r, 32'h0);
      wr(5'h04, 4'b1111, 32'h0000_8000);
      @(negedge clk);
    end

    // R5 key restart, ps = 2
    nper = 128;
    wr(5'h00, 4'b0011, 32'h0000_0200);
    wr(5'h08, 4'b1111, 32'h0000_8000);
    count_pulses(60, p); check("R5 no early pulse", p, 0);
    wr(5'h00, 4'b1100, 32'h5743_0000);
    wait_pulse(nper + 4, k); check("R5 restart period", k, nper);

    // R6 wrong value, wrong byte enables
    count_pulses(40, p); check("R6 quiet", p, 0);
    wr(5'h00, 4'b1100, 32'h5744_0000);
    wr(5'h00, 4'b1111, 32'h5743_8200);
    wr(5'h00, 4'b0100, 32'h5743_0000);
    wait_pulse(nper + 4, k); check("R6 no restart", k, nper - 43);

    // R7 key while disabled
    wr(5'h04, 4'b1111, 32'h0000_8000);
    @(negedge clk);
    wr(5'h00, 4'b1100, 32'h5743_0000);
    rd(5'h00, r); check("R7 ctrl unchanged", r, 32'h0200);
    count_pulses(nper + 40, p); check("R7 no pulse", p, 0);
    wr(5'h08, 4'b1111, 32'h0000_8000);
    wait_pulse(nper + 4, k); check("R8 enable full period", k, nper);

    // R8 disable mid-count then re-enable
    count_pulses(100, p); check("R8 quiet", p, 0);
    wr(5'h04, 4'b1111, 32'h0000_8000);
    @(negedge clk);
    wr(5'h08, 4'b1111, 32'h0000_8000);
    wait_pulse(nper + 4, k); check("R8 restart from zero", k, nper);

    // R10 guard cycle after enable falls
    wr(5'h04, 4'b1111, 32'h0000_8000);
    rd(5'h00, r); check("R10 read zero", r, 32'h0);
    wr(5'h08, 4'b1111, 32'h0000_8000);
    rd(5'h00, r); check("R10 write ignored", r, 32'h0200);
    count_pulses(nper + 40, p); check("R10 stays off", p, 0);

    // R9 survival and clearing rules
    rd(5'h10, r); check("R9 flag held", r, 32'h10);
    wr(5'h10, 4'b1111, 32'h0); rd(5'h10, r); check("R9 plain write", r, 32'h10);
    rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rd(5'h00, r); check("R1 ctrl after rst", r, 32'h0);
    rd(5'h10, r); check("R9 survives rst", r, 32'h10);
    wr(5'h14, 4'b1111, 32'h0); rd(5'h10, r); check("R9 clr bit0", r, 32'h10);
    wr(5'h14, 4'b1111, 32'h10); rd(5'h10, r); check("R9 clr bit1", r, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule